// File: doc/BRIEF.md
# H-Bridge PWM Modulator

This block turns one signed modulation command into the four gate signals of a full H-bridge. An up-counting carrier sets the switching period. Each of the two bridge legs compares the carrier against a compare value and produces a high-side gate and a complementary low-side gate. A programmable dead band separates the two gates of a leg. In bipolar switching both legs toggle in antiphase around half the period. In unipolar switching only one leg is pulsed, and the sign of the command picks that leg, while the other leg rests with its low-side switch on. The command magnitude is limited to a configurable ceiling before it is used.

A controller writes the period, modulation, mode and limit, then pulses a commit strobe. The block holds these settings in staging registers and moves them into the working set only when the carrier wraps. The period and the compare value therefore always change together at a cycle boundary. When the run input is low or the fault input is high, all four gates go low and new modulation and mode values are refused; a new period is still accepted. A one-cycle trigger marks a fixed carrier count early in each cycle so that current sampling can be aligned with the carrier.

Top module: `hbridge_pwm`

## Requirements
- R1: The carrier counts 0 up to P-1 and then returns to 0, where P is the committed period (values below 2 are raised to 2). After reset P is the parameter RST_PERIOD, 1024 by default, and consecutive trigger pulses are P cycles apart.
- R2: adc_trig_o is a single-cycle pulse, raised in the cycle after the carrier equals TRIG_CNT (default 200). It pulses once per carrier cycle when P exceeds TRIG_CNT.
- R3: mod_i is a Q1.15 two's complement value. Its magnitude is limited to mod_max_i, an unsigned 15-bit magnitude, and the sign is kept.
- R4: With mode_i = 0 (bipolar), the compare value is C = (P * (m + 32768)) >> 16, where m is the limited command. Leg A conducts high while count < C, and leg B conducts high while count >= C.
- R5: With mode_i = 1 (unipolar), C = (P * |m|) >> 15. For m >= 0, leg A is pulsed while count < C, and leg B holds its high gate low and its low gate high. For m < 0 the two legs swap roles.
- R6: At every reference change of a leg, both gates of that leg stay low for dead_i cycles. A leg's high and low gates are never high together. In steady state a high gate is on for C - dead_i cycles per period.
- R7: One clock edge after run_i is low or fault_i is high, all four gates are low, and they stay low while that condition lasts.
- R8: A commit made while run_i is low or fault_i is high leaves the stored modulation and mode unchanged.
- R9: Committed settings take effect at the first carrier wrap after the commit. The period that is running completes unchanged.
- R10: A committed period change recomputes the compare value from the stored modulation and mode.
- R11: During and after reset all gates and the trigger are low. The working set is bipolar, modulation 0, period RST_PERIOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Carrier period in clock counts, staged on commit |
| mod_i | input | 16 | Signed Q1.15 modulation command |
| mod_max_i | input | 15 | Magnitude ceiling for the command |
| mode_i | input | 1 | 0 = bipolar, 1 = unipolar |
| commit_i | input | 1 | Strobe that stages the settings for the next wrap |
| run_i | input | 1 | High to switch, low for the idle state |
| fault_i | input | 1 | High forces the idle state and blocks new commands |
| dead_i | input | DT_W (8) | Dead band in clock cycles |
| a_hi_o | output | 1 | Leg A high-side gate |
| a_lo_o | output | 1 | Leg A low-side gate |
| b_hi_o | output | 1 | Leg B high-side gate |
| b_lo_o | output | 1 | Leg B low-side gate |
| adc_trig_o | output | 1 | One-cycle sampling trigger |

## Verification
If the working compare value or period is wrong, the gate on-times and the trigger spacing measured over one carrier cycle are wrong. This shows within one period of the wrap where the bad value was loaded. A staging register that loads early or ignores the stop condition gives a trigger gap of the new period before the old one ends, or a duty that follows a refused command. Both are visible within two carrier cycles. A faulty dead-band counter shows at once as overlapping gates or as on-times that differ from C minus the dead band.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;

    localparam int unsigned HB_CNT_W   = 16;
    localparam int unsigned HB_MOD_W   = 16;
    localparam int unsigned HB_MAG_W   = HB_MOD_W - 1;
    localparam int unsigned HB_PER_MIN = 2;
    localparam int unsigned HB_PROD_W  = HB_CNT_W + HB_MOD_W;

    typedef logic [HB_CNT_W-1:0] cnt_t;
    typedef logic [HB_MAG_W-1:0] mag_t;

    typedef enum logic {
        SW_BIPOLAR  = 1'b0,
        SW_UNIPOLAR = 1'b1
    } sw_mode_e;

    // sign/magnitude form of the limited command
    typedef struct packed {
        logic neg;
        mag_t mag;
    } cmd_t;

    // working set used by the legs
    typedef struct packed {
        cnt_t     period;
        cnt_t     cmp;
        sw_mode_e mode;
        logic     neg;
    } leg_cfg_t;

    function automatic cmd_t limit_cmd(logic [HB_MOD_W-1:0] raw, mag_t lim);
        logic [HB_MOD_W-1:0] abs_v;
        cmd_t r;
        r.neg = raw[HB_MOD_W-1];
        abs_v = r.neg ? (~raw + 1'b1) : raw;
        if (abs_v > {1'b0, lim}) r.mag = lim;
        else                     r.mag = abs_v[HB_MAG_W-1:0];
        if (r.mag == '0) r.neg = 1'b0;
        return r;
    endfunction

    function automatic cnt_t calc_cmp(cnt_t per, cmd_t c, sw_mode_e m);
        logic [HB_PROD_W-1:0] prod;
        logic [HB_MOD_W-1:0]  half;
        logic [HB_MOD_W-1:0]  off;
        half = HB_MOD_W'(1) << HB_MAG_W;
        if (m == SW_BIPOLAR) begin
            off  = c.neg ? (half - HB_MOD_W'(c.mag)) : (half + HB_MOD_W'(c.mag));
            prod = HB_PROD_W'(per) * HB_PROD_W'(off);
            return prod[HB_MOD_W +: HB_CNT_W];
        end else begin
            prod = HB_PROD_W'(per) * HB_PROD_W'(c.mag);
            return prod[HB_MAG_W +: HB_CNT_W];
        end
    endfunction

endpackage

// File: rtl/hbpwm_carrier.sv
module hbpwm_carrier
    import hbpwm_pkg::*;
#(
    parameter int unsigned TRIG_CNT = 200
) (
    input  logic clk,
    input  logic rst,
    input  cnt_t period,
    output cnt_t cnt,
    output logic wrap,
    output logic trig
);

    localparam cnt_t TRIG_AT = cnt_t'(TRIG_CNT);

    assign wrap = (cnt >= period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            trig <= 1'b0;
        end else begin
            cnt  <= wrap ? '0 : cnt + 1'b1;
            trig <= (cnt == TRIG_AT);
        end
    end

endmodule

// File: rtl/hbpwm_shadow.sv
module hbpwm_shadow
    import hbpwm_pkg::*;
#(
    parameter int unsigned RST_PERIOD = 1024
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     commit,
    input  logic     accept_cmd,
    input  logic     wrap,
    input  cnt_t     period_in,
    input  logic [HB_MOD_W-1:0] mod_in,
    input  mag_t     lim_in,
    input  sw_mode_e mode_in,
    output leg_cfg_t act
);

    localparam cnt_t     RST_P   = cnt_t'(RST_PERIOD);
    localparam leg_cfg_t RST_CFG = '{period: RST_P,
                                     cmp:    calc_cmp(RST_P, cmd_t'('0), SW_BIPOLAR),
                                     mode:   SW_BIPOLAR,
                                     neg:    1'b0};

    cnt_t     stg_per;
    cmd_t     stg_cmd;
    sw_mode_e stg_mode;
    logic     pending;
    cnt_t     per_lim;

    assign per_lim = (period_in < cnt_t'(HB_PER_MIN)) ? cnt_t'(HB_PER_MIN) : period_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_per  <= RST_P;
            stg_cmd  <= '0;
            stg_mode <= SW_BIPOLAR;
            pending  <= 1'b0;
            act      <= RST_CFG;
        end else begin
            if (commit) begin
                stg_per <= per_lim;
                if (accept_cmd) begin
                    stg_cmd  <= limit_cmd(mod_in, lim_in);
                    stg_mode <= mode_in;
                end
            end
            pending <= commit | (pending & ~wrap);
            if (wrap && pending) begin
                act.period <= stg_per;
                act.cmp    <= calc_cmp(stg_per, stg_cmd, stg_mode);
                act.mode   <= stg_mode;
                act.neg    <= stg_cmd.neg;
            end
        end
    end

endmodule

// File: rtl/hbpwm_deadband.sv
module hbpwm_deadband #(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dead,
    output logic            hi,
    output logic            lo
);

    logic            ref_q;
    logic [DT_W-1:0] gap;
    logic [DT_W-1:0] gap_nx;

    always_comb begin
        if (ref_i != ref_q)  gap_nx = dead;
        else if (gap != '0)  gap_nx = gap - 1'b1;
        else                 gap_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            gap   <= '0;
            hi    <= 1'b0;
            lo    <= 1'b0;
        end else if (!en) begin
            ref_q <= ref_i;
            gap   <= dead;
            hi    <= 1'b0;
            lo    <= 1'b0;
        end else begin
            ref_q <= ref_i;
            gap   <= gap_nx;
            hi    <= ref_i  && (gap_nx == '0);
            lo    <= !ref_i && (gap_nx == '0);
        end
    end

endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm
    import hbpwm_pkg::*;
#(
    parameter int unsigned DT_W       = 8,
    parameter int unsigned TRIG_CNT   = 200,
    parameter int unsigned RST_PERIOD = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HB_CNT_W-1:0] period_i,
    input  logic [HB_MOD_W-1:0] mod_i,
    input  logic [HB_MAG_W-1:0] mod_max_i,
    input  logic                mode_i,
    input  logic                commit_i,
    input  logic                run_i,
    input  logic                fault_i,
    input  logic [DT_W-1:0]     dead_i,
    output logic                a_hi_o,
    output logic                a_lo_o,
    output logic                b_hi_o,
    output logic                b_lo_o,
    output logic                adc_trig_o
);

    localparam int unsigned N_LEG = 2;

    leg_cfg_t         act_cfg;
    cnt_t             car_cnt;
    cnt_t             act_period;
    logic             car_wrap;
    logic             run_ok;
    logic             below;
    logic [N_LEG-1:0] leg_ref;
    logic [N_LEG-1:0] leg_hi;
    logic [N_LEG-1:0] leg_lo;

    assign run_ok     = run_i & ~fault_i;
    assign act_period = act_cfg.period;

    hbpwm_carrier #(.TRIG_CNT(TRIG_CNT)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .period (act_cfg.period),
        .cnt    (car_cnt),
        .wrap   (car_wrap),
        .trig   (adc_trig_o)
    );

    hbpwm_shadow #(.RST_PERIOD(RST_PERIOD)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit_i),
        .accept_cmd (run_ok),
        .wrap       (car_wrap),
        .period_in  (period_i),
        .mod_in     (mod_i),
        .lim_in     (mod_max_i),
        .mode_in    (sw_mode_e'(mode_i)),
        .act        (act_cfg)
    );

    // leg 0 = A, leg 1 = B
    always_comb begin
        below = (car_cnt < act_cfg.cmp);
        case (act_cfg.mode)
            SW_BIPOLAR: leg_ref = {~below, below};
            default:    leg_ref = {below & act_cfg.neg, below & ~act_cfg.neg};
        endcase
    end

    for (genvar g = 0; g < N_LEG; g++) begin : g_leg
        hbpwm_deadband #(.DT_W(DT_W)) u_db (
            .clk   (clk),
            .rst   (rst),
            .en    (run_ok),
            .ref_i (leg_ref[g]),
            .dead  (dead_i),
            .hi    (leg_hi[g]),
            .lo    (leg_lo[g])
        );
    end

    assign a_hi_o = leg_hi[0];
    assign a_lo_o = leg_lo[0];
    assign b_hi_o = leg_hi[1];
    assign b_lo_o = leg_lo[1];

endmodule

// File: rtl/hbridge_pwm_chk.sv
module hbridge_pwm_chk
    import hbpwm_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic run_i,
    input logic fault_i,
    input logic a_hi,
    input logic a_lo,
    input logic b_hi,
    input logic b_lo,
    input logic trig,
    input cnt_t cnt,
    input cnt_t per
);

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(a_hi && a_lo) && !(b_hi && b_lo));

    a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!run_i || fault_i) |=> !(a_hi || a_lo || b_hi || b_lo));

    a_r2_trig_single: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt < per);

    a_r9_load_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(per) |-> (cnt == '0));

endmodule

bind hbridge_pwm hbridge_pwm_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run_i),
    .fault_i (fault_i),
    .a_hi    (a_hi_o),
    .a_lo    (a_lo_o),
    .b_hi    (b_hi_o),
    .b_lo    (b_lo_o),
    .trig    (adc_trig_o),
    .cnt     (car_cnt),
    .per     (act_period)
);

// File: tb/test_hbridge_pwm.sv
`timescale 1ns/1ps
module test_hbridge_pwm;

    typedef struct packed {
        logic        mode;
        logic [15:0] mod;
        logic [15:0] per;
        logic [7:0]  dead;
        logic [15:0] ah;
        logic [15:0] al;
        logic [15:0] bh;
        logic [15:0] bl;
    } vec_t;

    // expected on-times per period follow R4/R5 compare values minus the dead band (R6)
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 16'd256, 8'd4, 16'd124, 16'd124, 16'd124, 16'd124},
        '{1'b0, 16'h4000, 16'd256, 8'd4, 16'd188, 16'd60,  16'd60,  16'd188},
        '{1'b0, 16'hC000, 16'd256, 8'd4, 16'd60,  16'd188, 16'd188, 16'd60},
        '{1'b1, 16'h2000, 16'd256, 8'd4, 16'd60,  16'd188, 16'd0,   16'd256},
        '{1'b1, 16'hE000, 16'd256, 8'd4, 16'd0,   16'd256, 16'd60,  16'd188},
        '{1'b1, 16'h7FFF, 16'd256, 8'd4, 16'd220, 16'd28,  16'd0,   16'd256},
        '{1'b0, 16'h8000, 16'd256, 8'd4, 16'd12,  16'd236, 16'd236, 16'd12},
        '{1'b1, 16'h0000, 16'd256, 8'd4, 16'd0,   16'd256, 16'd0,   16'd256},
        '{1'b1, 16'h4000, 16'd300, 8'd4, 16'd146, 16'd146, 16'd0,   16'd300},
        '{1'b0, 16'h0000, 16'd256, 8'd0, 16'd128, 16'd128, 16'd128, 16'd128}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] period_i = 16'd256;
    logic [15:0] mod_i = '0;
    logic [14:0] mod_max_i = 15'h7000;
    logic        mode_i = 1'b0;
    logic        commit_i = 1'b0;
    logic        run_i = 1'b0;
    logic        fault_i = 1'b0;
    logic [7:0]  dead_i = 8'd4;
    logic        a_hi_o, a_lo_o, b_hi_o, b_lo_o, adc_trig_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hbridge_pwm i_hbridge_pwm (
        .clk        (clk),
        .rst        (rst),
        .period_i   (period_i),
        .mod_i      (mod_i),
        .mod_max_i  (mod_max_i),
        .mode_i     (mode_i),
        .commit_i   (commit_i),
        .run_i      (run_i),
        .fault_i    (fault_i),
        .dead_i     (dead_i),
        .a_hi_o     (a_hi_o),
        .a_lo_o     (a_lo_o),
        .b_hi_o     (b_hi_o),
        .b_lo_o     (b_lo_o),
        .adc_trig_o (adc_trig_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic commit(input logic md, input logic [15:0] m, input logic [15:0] p);
        @(negedge clk);
        mode_i = md; mod_i = m; period_i = p; commit_i = 1'b1;
        @(negedge clk);
        commit_i = 1'b0;
    endtask

    task automatic measure(input int n, output int ah, output int al,
                           output int bh, output int bl, output int ov);
        ah = 0; al = 0; bh = 0; bl = 0; ov = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ah += int'(a_hi_o); al += int'(a_lo_o);
            bh += int'(b_hi_o); bl += int'(b_lo_o);
            if ((a_hi_o && a_lo_o) || (b_hi_o && b_lo_o)) ov++;
        end
    endtask

    task automatic wait_trig();
        do @(negedge clk); while (!adc_trig_o);
    endtask

    task automatic trig_gap(output int g);
        wait_trig();
        g = 0;
        do begin @(negedge clk); g++; end while (!adc_trig_o);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int ah, al, bh, bl, ov, g, gate_sum;
        string tag;

        // R11: reset state
        repeat (5) @(negedge clk);
        check("R11", "gates in reset", int'({a_hi_o, a_lo_o, b_hi_o, b_lo_o}), 0);
        check("R11", "trigger in reset", int'(adc_trig_o), 0);
        rst = 1'b0;
        run_i = 1'b1;
        repeat (100) @(negedge clk);
        measure(1024, ah, al, bh, bl, ov);
        check("R11", "reset duty a_hi", ah, 508);
        trig_gap(g);
        check("R1", "reset period trigger gap", g, 1024);

        // table of vectors: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            dead_i = VECS[v].dead;
            commit(VECS[v].mode, VECS[v].mod, VECS[v].per);
            repeat (1100 + 2 * int'(VECS[v].per)) @(negedge clk);
            measure(int'(VECS[v].per), ah, al, bh, bl, ov);
            tag = VECS[v].mode ? "R5" : "R4";
            if (v == 5 || v == 6) tag = {tag, "/R3"};
            if (v == 9) tag = {tag, "/R6"};
            check(tag, $sformatf("vec%0d a_hi", v), ah, int'(VECS[v].ah));
            check(tag, $sformatf("vec%0d a_lo", v), al, int'(VECS[v].al));
            check(tag, $sformatf("vec%0d b_hi", v), bh, int'(VECS[v].bh));
            check(tag, $sformatf("vec%0d b_lo", v), bl, int'(VECS[v].bl));
            check("R6", $sformatf("vec%0d overlap", v), ov, 0);
        end
        trig_gap(g);
        check("R2", "trigger gap at P=256", g, 256);

        // R9: commit just after a trigger; running period finishes first
        wait_trig();
        period_i = 16'd512; commit_i = 1'b1;
        g = 0;
        do begin @(negedge clk); commit_i = 1'b0; g++; end while (!adc_trig_o);
        check("R9", "gap after commit keeps old period", g, 256);
        g = 0;
        do begin @(negedge clk); g++; end while (!adc_trig_o);
        check("R9", "next gap uses new period", g, 512);

        // R7: stop
        dead_i = 8'd4;
        @(negedge clk);
        run_i = 1'b0;
        @(negedge clk);
        check("R7", "gates one edge after stop", int'({a_hi_o, a_lo_o, b_hi_o, b_lo_o}), 0);
        // R8: commands refused while stopped, period accepted
        commit(1'b1, 16'h2000, 16'd384);
        measure(1200, ah, al, bh, bl, ov);
        gate_sum = ah + al + bh + bl;
        check("R7", "gates held low while stopped", gate_sum, 0);
        run_i = 1'b1;
        repeat (1200) @(negedge clk);
        measure(384, ah, al, bh, bl, ov);
        check("R8", "b_hi shows refused unipolar command", bh, 188);
        check("R10", "a_hi recomputed for new period", ah, 188);
        trig_gap(g);
        check("R10", "trigger gap new period", g, 384);

        // R7/R8: fault
        @(negedge clk);
        fault_i = 1'b1;
        @(negedge clk);
        check("R7", "gates one edge after fault", int'({a_hi_o, a_lo_o, b_hi_o, b_lo_o}), 0);
        commit(1'b0, 16'h4000, 16'd384);
        measure(20, ah, al, bh, bl, ov);
        check("R7", "gates held low during fault", ah + al + bh + bl, 0);
        fault_i = 1'b0;
        repeat (1200) @(negedge clk);
        measure(384, ah, al, bh, bl, ov);
        check("R8", "command during fault refused", ah, 188);
        check("R6", "no overlap after fault", ov, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule